// File: doc/BRIEF.md
# Interrupt Gathering and Sleep-State Controller

This block collects every interrupt request of a small low-power microcontroller and decides when its main clock runs. Eight external port pins are watched for edges, each pin with its own choice of rising or falling edge, and five internal peripherals (a time-base timer, two counters, a UART and an SPI unit) raise single-cycle request strobes. Every source owns a sticky pending flag and an enable bit. An enabled pending flag produces the interrupt request to the core.

The block also holds the power state: run, sleep1 or sleep2. Both sleep states drop the main clock enable. Sleep1 is entered by the sleep instruction, and only when the watchdog is enabled. It is left only by a watchdog time-out or an external reset, and the core then restarts from reset. Sleep2 is entered by setting a sleep-control bit. Any enabled pending interrupt ends it, and the core resumes with its context intact. The detector and the state machine run on an always-on clock, so edges are still seen while the main clock is stopped.

Top module: `irqSleepCtrl`

## Requirements
- R1: After `porN` is released, `powerState` is 0 (run), `mainClkEn` is 1, and `pending`, `irqToCore`, `slpcBit`, `coreResetReq` and `resumePulse` are all 0.
- R2: External pin i sets `pending[i]` (bits 0 to 7) on its selected edge (`edgeSel[i]` = 1 for rising, 0 for falling). The flag appears on the third rising clock edge after the pin changes. The opposite edge never sets the flag.
- R3: Internal request k sets `pending[8+k]` on the clock edge where it is high. The sources are assigned as k = 0 time-base timer, 1 counter 1, 2 counter 2, 3 UART, 4 SPI.
- R4: Pending flags stay set until a `clearWr` strobe with a 1 in that bit of `clearMask`. Bits with a 0 in the mask are not touched. A new request in the same cycle as its clear leaves the flag set.
- R5: `irqToCore` is 1 exactly when the state is run and at least one pending flag has its `irqEnable` bit set.
- R6: `sleepInstr` in run with `wdtEnable` high moves to sleep1 (`powerState` 1, `mainClkEn` 0). With `wdtEnable` low it is ignored and the state stays run.
- R7: Sleep1 ignores all interrupts. A reset event leaves it: `extResetReq`, or `wdtTimeout` while `wdtEnable` is high. A reset event in any state goes to run on the next edge, clears all pending flags and `slpcBit`, and gives a one-cycle `coreResetReq`. `wdtTimeout` with `wdtEnable` low has no effect.
- R8: `slpcSet` in run moves to sleep2 (`powerState` 2, `mainClkEn` 0) and sets `slpcBit`.
- R9: In sleep2, an enabled pending flag returns the block to run on the next edge. The same edge clears `slpcBit` and raises `resumePulse` for one cycle, and the pending flags are kept. Pending flags that are not enabled do not wake the block. External edges are still detected during sleep2.
- R10: When requests arrive in the same cycle, a reset event wins over `sleepInstr`, and `sleepInstr` wins over `slpcSet`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| extResetReq | input | 1 | External reset request |
| wdtEnable | input | 1 | Watchdog enabled |
| wdtTimeout | input | 1 | Watchdog time-out strobe |
| extPins | input | 8 | External interrupt pins |
| edgeSel | input | 8 | Per-pin edge choice, 1 rising, 0 falling |
| intReq | input | 5 | Internal request strobes |
| irqEnable | input | 13 | Per-source enable |
| clearWr | input | 1 | Write-1-to-clear strobe |
| clearMask | input | 13 | Bits to clear |
| sleepInstr | input | 1 | Sleep instruction executed |
| slpcSet | input | 1 | Write of 1 to the sleep-control bit |
| pending | output | 13 | Sticky pending flags |
| irqToCore | output | 1 | Interrupt request to the core |
| slpcBit | output | 1 | Sleep-control bit readback |
| mainClkEn | output | 1 | Main clock enable |
| powerState | output | 2 | 0 run, 1 sleep1, 2 sleep2 |
| coreResetReq | output | 1 | Core restart pulse |
| resumePulse | output | 1 | Context-keeping wake pulse |

## Verification
A wrong power state appears at `mainClkEn` and `powerState` one edge after the request that caused it. A missed or spurious wake shows up as a missing or extra `resumePulse` or `coreResetReq` in that same cycle. A broken synchroniser or edge compare is visible at `pending` exactly three edges after a pin change, as a flag that comes too early, too late, or on the wrong edge. A bad enable mask shows at `irqToCore` without any clock edge.

// File: rtl/irqSleepPkg.sv
package irqSleepPkg;
  localparam int DEF_NUM_EXT = 8;
  localparam int DEF_NUM_INT = 5;

  typedef enum logic [1:0] {
    PWR_RUN    = 2'd0,
    PWR_SLEEP1 = 2'd1,
    PWR_SLEEP2 = 2'd2
  } pwrState_t;

  typedef struct packed {
    logic flushPending;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqSleepDatapath.sv
module irqSleepDatapath
  import irqSleepPkg::*;
#(
  parameter int NUM_EXT = DEF_NUM_EXT,
  parameter int NUM_INT = DEF_NUM_INT,
  localparam int NUM_SRC = NUM_EXT + NUM_INT
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [NUM_EXT-1:0] extPins,
  input  logic [NUM_EXT-1:0] edgeSel,
  input  logic [NUM_INT-1:0] intReq,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic               clearWr,
  input  logic [NUM_SRC-1:0] clearMask,
  input  ctrlStrobes_t       strobes,
  output logic [NUM_SRC-1:0] pendQ,
  output logic               wakeAny
);
  logic [NUM_EXT-1:0] syncA, syncB, lastLvl, extHit;
  logic [NUM_SRC-1:0] setVec;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      syncA   <= '0;
      syncB   <= '0;
      lastLvl <= '0;
    end else begin
      syncA   <= extPins;
      syncB   <= syncA;
      lastLvl <= syncB;
    end
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_edge
    always_comb begin
      if (edgeSel[i]) extHit[i] = syncB[i] & ~lastLvl[i];
      else            extHit[i] = ~syncB[i] & lastLvl[i];
    end
  end

  assign setVec = {intReq, extHit};

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pendQ <= '0;
    end else if (strobes.flushPending) begin
      pendQ <= '0;
    end else begin
      pendQ <= setVec | (pendQ & ~(clearWr ? clearMask : '0));
    end
  end

  assign wakeAny = |(pendQ & irqEnable);

  for (genvar j = 0; j < NUM_SRC; j++) begin : g_chk
    // R4: a flag survives every cycle that neither clears nor flushes it
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!porN)
      (pendQ[j] && !strobes.flushPending && !(clearWr && clearMask[j])) |=> pendQ[j]);
  end

  for (genvar k = 0; k < NUM_INT; k++) begin : g_intchk
    assert_int_capture_R3: assert property (@(posedge clk) disable iff (!porN)
      (intReq[k] && !strobes.flushPending) |=> pendQ[NUM_EXT+k]);
  end

  assert_flush_R7: assert property (@(posedge clk) disable iff (!porN)
    strobes.flushPending |=> (pendQ == '0));
endmodule

// File: rtl/irqSleepControl.sv
module irqSleepControl
  import irqSleepPkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         extResetReq,
  input  logic         wdtEnable,
  input  logic         wdtTimeout,
  input  logic         sleepInstr,
  input  logic         slpcSet,
  input  logic         wakeAny,
  output ctrlStrobes_t strobes,
  output pwrState_t    stateQ,
  output logic         slpcQ,
  output logic         coreResetQ,
  output logic         resumeQ
);
  logic resetEvt;

  assign resetEvt = extResetReq | (wdtEnable & wdtTimeout);
  assign strobes.flushPending = resetEvt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stateQ     <= PWR_RUN;
      slpcQ      <= 1'b0;
      coreResetQ <= 1'b0;
      resumeQ    <= 1'b0;
    end else begin
      coreResetQ <= resetEvt;
      resumeQ    <= 1'b0;
      if (resetEvt) begin
        stateQ <= PWR_RUN;
        slpcQ  <= 1'b0;
      end else begin
        unique case (stateQ)
          PWR_RUN: begin
            if (sleepInstr && wdtEnable) begin
              stateQ <= PWR_SLEEP1;
            end else if (slpcSet) begin
              stateQ <= PWR_SLEEP2;
              slpcQ  <= 1'b1;
            end
          end
          PWR_SLEEP1: stateQ <= PWR_SLEEP1;
          PWR_SLEEP2: begin
            if (wakeAny) begin
              stateQ  <= PWR_RUN;
              slpcQ   <= 1'b0;
              resumeQ <= 1'b1;
            end
          end
          default: stateQ <= PWR_RUN;
        endcase
      end
    end
  end

  assert_refuse_sleep_R6: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == PWR_RUN && !resetEvt && !wdtEnable && !slpcSet) |=> (stateQ == PWR_RUN));
  assert_sleep1_hold_R7: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == PWR_SLEEP1 && !resetEvt) |=> (stateQ == PWR_SLEEP1));
  assert_reset_exit_R7: assert property (@(posedge clk) disable iff (!porN)
    resetEvt |=> (stateQ == PWR_RUN && !slpcQ && coreResetQ));
  assert_sleep2_wake_R9: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == PWR_SLEEP2 && wakeAny && !resetEvt) |=> (stateQ == PWR_RUN && !slpcQ && resumeQ));
  assert_sleep2_hold_R9: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == PWR_SLEEP2 && !wakeAny && !resetEvt) |=> (stateQ == PWR_SLEEP2 && slpcQ));
  assert_slpc_state_R8: assert property (@(posedge clk) disable iff (!porN)
    slpcQ |-> (stateQ == PWR_SLEEP2));
endmodule

// File: rtl/irqSleepCtrl.sv
module irqSleepCtrl
  import irqSleepPkg::*;
#(
  parameter int NUM_EXT = DEF_NUM_EXT,
  parameter int NUM_INT = DEF_NUM_INT,
  localparam int NUM_SRC = NUM_EXT + NUM_INT
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               extResetReq,
  input  logic               wdtEnable,
  input  logic               wdtTimeout,
  input  logic [NUM_EXT-1:0] extPins,
  input  logic [NUM_EXT-1:0] edgeSel,
  input  logic [NUM_INT-1:0] intReq,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic               clearWr,
  input  logic [NUM_SRC-1:0] clearMask,
  input  logic               sleepInstr,
  input  logic               slpcSet,
  output logic [NUM_SRC-1:0] pending,
  output logic               irqToCore,
  output logic               slpcBit,
  output logic               mainClkEn,
  output logic [1:0]         powerState,
  output logic               coreResetReq,
  output logic               resumePulse
);
  ctrlStrobes_t strobes;
  pwrState_t    stateQ;
  logic         wakeAny;

  irqSleepDatapath #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT)) u_dp (
    .clk(clk), .porN(porN), .extPins(extPins), .edgeSel(edgeSel),
    .intReq(intReq), .irqEnable(irqEnable), .clearWr(clearWr),
    .clearMask(clearMask), .strobes(strobes), .pendQ(pending),
    .wakeAny(wakeAny)
  );

  irqSleepControl u_ctl (
    .clk(clk), .porN(porN), .extResetReq(extResetReq),
    .wdtEnable(wdtEnable), .wdtTimeout(wdtTimeout),
    .sleepInstr(sleepInstr), .slpcSet(slpcSet), .wakeAny(wakeAny),
    .strobes(strobes), .stateQ(stateQ), .slpcQ(slpcBit),
    .coreResetQ(coreResetReq), .resumeQ(resumePulse)
  );

  assign mainClkEn  = (stateQ == PWR_RUN);
  assign irqToCore  = wakeAny && (stateQ == PWR_RUN);
  assign powerState = stateQ;

  assert_no_irq_asleep_R5: assert property (@(posedge clk) disable iff (!porN)
    irqToCore |-> mainClkEn);
endmodule

// File: tb/irqSleepCtrl_bench.sv
module irqSleepCtrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        extResetReq = 0, wdtEnable = 0, wdtTimeout = 0;
  logic [7:0]  extPins = '0, edgeSel = '0;
  logic [4:0]  intReq = '0;
  logic [12:0] irqEnable = '0, clearMask = '0;
  logic        clearWr = 0, sleepInstr = 0, slpcSet = 0;
  logic [12:0] pending;
  logic        irqToCore, slpcBit, mainClkEn, coreResetReq, resumePulse;
  logic [1:0]  powerState;

  int nChecks = 0, nFail = 0, cycles = 0;
  bit done = 0;

  irqSleepCtrl u_irqSleepCtrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT && !done) begin
      nFail++;
      $display("FAIL watchdog: act %0d cycles exp fewer than %0d", cycles, WD_LIMIT);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    clearWr = 1; clearMask = '1;
    tick();
    clearWr = 0; clearMask = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state in reset", {30'd0, powerState}, 0);
    porN = 1;
    tick();
    chk("R1 powerState", {30'd0, powerState}, 0);
    chk("R1 mainClkEn", {31'd0, mainClkEn}, 1);
    chk("R1 pending", {19'd0, pending}, 0);
    chk("R1 outputs", {28'd0, irqToCore, slpcBit, coreResetReq, resumePulse}, 0);

    // R2 exhaustive pin x edge sweep
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 2; s++) begin
        edgeSel = s ? 8'hFF : 8'h00;
        clearAll();
        if (s == 1) begin
          extPins[i] = 1; tick(2);
          chk("R2 rise too early", {19'd0, pending}, 0);
          tick();
          chk("R2 rise set", {19'd0, pending}, 32'd1 << i);
          clearAll();
          extPins[i] = 0; tick(3);
          chk("R2 fall ignored", {19'd0, pending}, 0);
        end else begin
          extPins[i] = 1; tick(3);
          chk("R2 rise ignored", {19'd0, pending}, 0);
          extPins[i] = 0; tick(2);
          chk("R2 fall too early", {19'd0, pending}, 0);
          tick();
          chk("R2 fall set", {19'd0, pending}, 32'd1 << i);
        end
      end
    end
    clearAll();

    // R3 / R5 exhaustive over internal pending and enable patterns
    for (int p = 0; p < 32; p++) begin
      clearAll();
      intReq = p[4:0]; tick(); intReq = '0;
      chk("R3 internal capture", {19'd0, pending}, p << 8);
      for (int e = 0; e < 32; e++) begin
        irqEnable = {e[4:0], 8'h00};
        #1;
        chk("R5 irqToCore", {31'd0, irqToCore}, ((p & e) != 0) ? 1 : 0);
      end
    end
    irqEnable = '0;

    // R4 clear mask and set-over-clear
    clearAll();
    intReq = 5'h1F; tick(); intReq = '0;
    clearWr = 1; clearMask = 13'h0500; tick(); clearWr = 0;
    chk("R4 partial clear", {19'd0, pending}, 32'h1A00);
    tick(2);
    chk("R4 sticky", {19'd0, pending}, 32'h1A00);
    intReq = 5'h02; clearWr = 1; clearMask = 13'h0200; tick();
    intReq = '0; clearWr = 0;
    chk("R4 set wins", {19'd0, pending}, 32'h1A00);
    clearMask = 13'h1FFF; tick();
    chk("R4 no strobe no clear", {19'd0, pending}, 32'h1A00);
    clearAll();

    // R6 sleep refused without watchdog, then accepted
    wdtEnable = 0; sleepInstr = 1; tick(); sleepInstr = 0;
    chk("R6 refused state", {30'd0, powerState}, 0);
    chk("R6 refused clk", {31'd0, mainClkEn}, 1);
    wdtEnable = 1; sleepInstr = 1; tick(); sleepInstr = 0;
    chk("R6 sleep1 state", {30'd0, powerState}, 1);
    chk("R6 sleep1 clk", {31'd0, mainClkEn}, 0);

    // R7 sleep1 ignores interrupts and disabled watchdog
    irqEnable = '1; intReq = 5'h1F; tick(); intReq = '0; tick(2);
    chk("R7 irq ignored", {30'd0, powerState}, 1);
    chk("R7 no core irq", {31'd0, irqToCore}, 0);
    wdtEnable = 0; wdtTimeout = 1; tick(); wdtTimeout = 0;
    chk("R7 disabled wdt ignored", {30'd0, powerState}, 1);
    wdtEnable = 1; wdtTimeout = 1; tick(); wdtTimeout = 0;
    chk("R7 wdt exit state", {30'd0, powerState}, 0);
    chk("R7 wdt core reset", {31'd0, coreResetReq}, 1);
    chk("R7 pending flushed", {19'd0, pending}, 0);
    tick();
    chk("R7 reset one cycle", {31'd0, coreResetReq}, 0);
    sleepInstr = 1; tick(); sleepInstr = 0;
    extResetReq = 1; tick(); extResetReq = 0;
    chk("R7 ext reset exit", {30'd0, powerState}, 0);
    chk("R7 ext core reset", {31'd0, coreResetReq}, 1);
    tick();

    // R8 / R9 sleep2 entry, disabled source, pin wake
    irqEnable = 13'h0001; edgeSel = 8'hFF;
    slpcSet = 1; tick(); slpcSet = 0;
    chk("R8 sleep2 state", {30'd0, powerState}, 2);
    chk("R8 slpc set", {31'd0, slpcBit}, 1);
    chk("R8 clk off", {31'd0, mainClkEn}, 0);
    intReq = 5'h01; tick(); intReq = '0; tick(2);
    chk("R9 disabled no wake", {30'd0, powerState}, 2);
    extPins[0] = 1; tick(3);
    chk("R9 edge seen asleep", {19'd0, pending}, 32'h0101);
    chk("R9 still asleep", {30'd0, powerState}, 2);
    tick();
    chk("R9 woke", {30'd0, powerState}, 0);
    chk("R9 slpc cleared", {31'd0, slpcBit}, 0);
    chk("R9 resume pulse", {31'd0, resumePulse}, 1);
    chk("R9 context kept", {19'd0, pending}, 32'h0101);
    chk("R9 irq to core", {31'd0, irqToCore}, 1);
    tick();
    chk("R9 pulse one cycle", {31'd0, resumePulse}, 0);
    extPins[0] = 0; tick(3);
    clearAll();

    // R10 priority
    sleepInstr = 1; slpcSet = 1; tick(); sleepInstr = 0; slpcSet = 0;
    chk("R10 instr over slpc", {30'd0, powerState}, 1);
    chk("R10 slpc not set", {31'd0, slpcBit}, 0);
    extResetReq = 1; tick(); extResetReq = 0; tick();
    extResetReq = 1; sleepInstr = 1; slpcSet = 1; tick();
    extResetReq = 0; sleepInstr = 0; slpcSet = 0;
    chk("R10 reset wins", {30'd0, powerState}, 0);
    chk("R10 reset pulse", {31'd0, coreResetReq}, 1);
    chk("R10 slpc clear", {31'd0, slpcBit}, 0);
    tick();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule